// File: doc/BRIEF.md
# I2C Stuck-Data Recovery Sequencer

This block frees a two-wire bus after a peripheral is left holding the data line low, for example when a reset or a supply glitch lands in the middle of a transfer. Software or a supervisor raises `start_i` for one cycle. The block first looks at the synchronised data line. If the line is low, the block clocks the bus itself, one pulse at a time, and checks the data line after each pulse. It stops as soon as the line has been let go, or when it reaches its pulse limit. In both cases it then drives a STOP condition on the bus and reports the result.

Both bus lines are open-drain. The block only asserts an output enable that pulls a line low, and a released line rises through external pull-ups. The raw line levels come back through `scl_i` and `sda_i`, and each passes through a two-flop synchroniser inside the block. The half-period of the generated clock is a cycle count that is captured when start is accepted. For example, 625 gives 100 kHz and 156 gives about 400 kHz from a 125 MHz clock. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `i2c_bus_unlock`

## Requirements
- R1: After reset `scl_oe_o`, `sda_oe_o`, `busy_o`, `done_o` and `fail_o` are all 0.
- R2: A start in idle is accepted. The next cycle is a single check cycle with both enables at 0. If the synchronised data line reads high in that cycle, the block generates no clock pulse and goes straight to the STOP sequence.
- R3: Each pulse pulls SCL low (`scl_oe_o`=1) for H cycles, then releases it. The high-phase timer starts only when the synchronised SCL reads high, which honours clock stretching. The high phase then lasts H cycles. H is `half_period_i` captured at start, with any value below 3 raised to 3.
- R4: The data line is sampled in the last cycle of each high phase. If it reads high, clocking stops and the STOP sequence begins.
- R5: At most 9 pulses are generated. If the data line is still low after the 9th pulse, `fail_o` rises and the STOP sequence follows. If the line is released on exactly the 9th pulse, this is a success.
- R6: The STOP sequence runs in this order: SCL low with SDA released for H cycles; SCL and SDA both low for H cycles; SCL released with SDA still low until SCL reads high, then H more cycles; both released for H cycles.
- R7: If the data line reads low in the last cycle of the STOP sequence, `fail_o` is set.
- R8: `fail_o` clears when a start is accepted and holds its value after `done_o` until the next accepted start.
- R9: `busy_o` is 1 from the cycle after start is accepted through the cycle in which `done_o` is 1. `done_o` is 1 for exactly one cycle, the one after the STOP sequence ends.
- R10: `start_i` has no effect while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a recovery run (accepted only in idle) |
| half_period_i | input | DIV_W | SCL half-period in clock cycles |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Recovery result: 1 means the bus is still stuck |

## Verification
The hardest cases to reach are the ones where the bus itself misbehaves:
- a peripheral that stretches every SCL high phase;
- one that lets go on exactly the ninth pulse;
- one that grabs SDA again while the STOP is being formed.

The bench models the two wires with behavioural peripheral state. A falling-edge counter sets when the peripheral lets go of SDA, and a release-age counter holds SCL low for a chosen number of cycles. Reaching these cases only takes setting those knobs before each start. A queue-based reference model builds the expected per-cycle enables and flags from the requirements, and the outputs are compared against it on every clock.

// File: rtl/unlk_pkg.sv
package unlk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LOW,
    ST_REL,
    ST_HIGH,
    ST_STOP_A,
    ST_STOP_B,
    ST_STOP_C,
    ST_STOP_CH,
    ST_STOP_D,
    ST_DONE
  } unlk_state_e;

  // States whose length is set by the half-period timer
  function automatic logic is_timed(unlk_state_e st);
    return (st == ST_LOW) || (st == ST_HIGH) || (st == ST_STOP_A) ||
           (st == ST_STOP_B) || (st == ST_STOP_CH) || (st == ST_STOP_D);
  endfunction

endpackage

// File: rtl/unlk_sync.sv
module unlk_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/unlk_phase_timer.sv
module unlk_phase_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] len_i,
  output logic             zero_o
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - DIV_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - DIV_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  // R3: an expired timer stays expired until reloaded
  a_r3_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/unlk_pulse_ctr.sv
module unlk_pulse_ctr #(
  parameter int MAX_PULSES = 9,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = (cnt_q == CW'(MAX_PULSES - 1));

  // R5: the pulse count never passes the cap
  a_r5_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_PULSES));

endmodule

// File: rtl/i2c_bus_unlock.sv
module i2c_bus_unlock
  import unlk_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int MIN_HALF   = 3,
  parameter int MAX_PULSES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_period_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);

  localparam logic [DIV_W-1:0] HALF_FLOOR = DIV_W'(MIN_HALF);

  unlk_state_e      state_q, state_d;
  logic [DIV_W-1:0] hp_q;
  logic             fail_q;
  logic             scl_s, sda_s;
  logic             tmr_load, tmr_zero;
  logic             pulse_inc, pulse_last;
  logic             accept;

  unlk_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({scl_i, sda_i}),
    .q_o  ({scl_s, sda_s})
  );

  unlk_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(tmr_load),
    .len_i (hp_q),
    .zero_o(tmr_zero)
  );

  unlk_pulse_ctr #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (accept),
    .inc_i (pulse_inc),
    .last_o(pulse_last)
  );

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d   = state_q;
    pulse_inc = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_CHECK;
      ST_CHECK:   state_d = sda_s ? ST_STOP_A : ST_LOW;
      ST_LOW:     if (tmr_zero) state_d = ST_REL;
      ST_REL:     if (scl_s) state_d = ST_HIGH;
      ST_HIGH: begin
        if (tmr_zero) begin
          pulse_inc = 1'b1;
          state_d   = (sda_s || pulse_last) ? ST_STOP_A : ST_LOW;
        end
      end
      ST_STOP_A:  if (tmr_zero) state_d = ST_STOP_B;
      ST_STOP_B:  if (tmr_zero) state_d = ST_STOP_C;
      ST_STOP_C:  if (scl_s) state_d = ST_STOP_CH;
      ST_STOP_CH: if (tmr_zero) state_d = ST_STOP_D;
      ST_STOP_D:  if (tmr_zero) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = is_timed(state_d) && (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hp_q    <= HALF_FLOOR;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        hp_q   <= (half_period_i < HALF_FLOOR) ? HALF_FLOOR : half_period_i;
        fail_q <= 1'b0;
      end else if (state_q == ST_HIGH && tmr_zero && !sda_s && pulse_last) begin
        fail_q <= 1'b1;
      end else if (state_q == ST_STOP_D && tmr_zero && !sda_s) begin
        fail_q <= 1'b1;
      end
    end
  end

  assign scl_oe_o = (state_q == ST_LOW) || (state_q == ST_STOP_A) || (state_q == ST_STOP_B);
  assign sda_oe_o = (state_q == ST_STOP_B) || (state_q == ST_STOP_C) || (state_q == ST_STOP_CH);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign fail_o   = fail_q;

  // R6: SDA is only pulled low while SCL is already held low
  a_r6_sda_low_under_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> (scl_oe_o && $past(scl_oe_o)));

  // R6: SDA is let go only with SCL released (STOP edge)
  a_r6_stop_edge_scl_free: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_oe_o);

  // R9: done is a single-cycle pulse inside busy
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  // R1: no line is pulled while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

  // R10: a run is never cut short before done
  a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/i2c_bus_unlock_bench.sv
module i2c_bus_unlock_bench;

  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [DIV_W-1:0] half_period_i = '0;
  logic             scl_oe, sda_oe, busy, done, fail;
  logic             scl_line, sda_line;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Peripheral model knobs
  int stuck_edges = 0;   // SDA held until this many SCL falling edges
  int stretch     = 0;   // cycles SCL is held low after release
  bit regrab      = 0;   // peripheral pulls SDA again after releasing
  int rel_age     = 0;
  int edges       = 0;
  logic prev_scl  = 1'b1;

  logic [4:0] exp_q[$];   // {scl_oe, sda_oe, busy, done, fail}
  logic       last_fail = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  assign scl_line = !scl_oe && (rel_age >= stretch);
  assign sda_line = !sda_oe && !((edges < stuck_edges) || (regrab && edges > stuck_edges));

  always @(negedge clk) begin
    rel_age  <= scl_oe ? 0 : (rel_age < 1000 ? rel_age + 1 : rel_age);
    prev_scl <= scl_line;
    if (!busy)                      edges <= 0;
    else if (prev_scl && !scl_line) edges <= edges + 1;
  end

  i2c_bus_unlock #(.DIV_W(DIV_W)) u_i2c_bus_unlock (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .half_period_i(half_period_i),
    .scl_i        (scl_line),
    .sda_i        (sda_line),
    .scl_oe_o     (scl_oe),
    .sda_oe_o     (sda_oe),
    .busy_o       (busy),
    .done_o       (done),
    .fail_o       (fail)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic push(int n, logic s, logic d, logic b, logic dn, logic f);
    for (int i = 0; i < n; i++) exp_q.push_back({s, d, b, dn, f});
  endtask

  // Build the expected per-cycle picture of one run from the requirements
  task automatic build(int hp);
    int  h;
    int  r;
    logic f;
    h = (hp < 3) ? 3 : hp;
    r = 2 + ((stretch < 1) ? 1 : stretch);
    f = 1'b0;
    push(1, 0, 0, 1, 0, 0);                       // R2 check cycle
    if (stuck_edges > 0) begin
      for (int p = 1; p <= 9; p++) begin
        push(h, 1, 0, 1, 0, f);                   // R3 low phase
        push(r, 0, 0, 1, 0, f);                   // R3 wait for SCL high
        push(h, 0, 0, 1, 0, f);                   // R3 high phase
        if (p >= stuck_edges) break;              // R4 released
        if (p == 9) f = 1'b1;                     // R5 cap reached
      end
    end
    push(h, 1, 0, 1, 0, f);                       // R6 STOP steps
    push(h, 1, 1, 1, 0, f);
    push(r, 0, 1, 1, 0, f);
    push(h, 0, 1, 1, 0, f);
    push(h, 0, 0, 1, 0, f);
    if (regrab || stuck_edges > 9) f = 1'b1;      // R7 / R5
    push(1, 0, 0, 1, 1, f);                       // R9 done
    last_fail = f;
  endtask

  task automatic compare(logic [4:0] e);
    logic [4:0] a;
    a = {scl_oe, sda_oe, busy, done, fail};
    checks = checks + 1;
    if (a !== e) begin
      fails = fails + 1;
      if (a[4] !== e[4]) $display("FAIL R3 scl_oe @%0d: actual %b expected %b", cyc, a[4], e[4]);
      if (a[3] !== e[3]) $display("FAIL R6 sda_oe @%0d: actual %b expected %b", cyc, a[3], e[3]);
      if (a[2] !== e[2]) $display("FAIL R9 busy @%0d: actual %b expected %b", cyc, a[2], e[2]);
      if (a[1] !== e[1]) $display("FAIL R9 done @%0d: actual %b expected %b", cyc, a[1], e[1]);
      if (a[0] !== e[0]) $display("FAIL R8 fail @%0d: actual %b expected %b", cyc, a[0], e[0]);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare({4'b0000, last_fail});
    end
  endtask

  // One run; extra_at >= 0 pulses start again at that cycle of the run (R10)
  task automatic run(int hp, int k, int s, bit rg, int extra_at);
    int i;
    stuck_edges = k;
    stretch = s;
    regrab = rg;
    idle(4);
    half_period_i = DIV_W'(hp);
    start_i = 1'b1;
    build(hp);
    @(negedge clk);
    start_i = 1'b0;
    i = 0;
    while (exp_q.size() > 0) begin
      compare(exp_q.pop_front());
      start_i = (i == extra_at);
      half_period_i = DIV_W'(hp + 7);
      i++;
      @(negedge clk);
    end
    start_i = 1'b0;
    compare({4'b0000, last_fail});
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(5'b00000);                 // R1 during reset
    rst_n = 1'b1;
    idle(4);                           // R1 after reset
    run(4, 0, 0, 0, -1);               // R2 line already free
    run(4, 3, 0, 0, 10);               // R3 R4 three pulses, R10 start mid-run
    run(5, 3, 6, 0, -1);               // R3 clock stretching
    run(3, 9, 0, 0, -1);               // R5 release on last pulse
    run(4, 12, 0, 0, -1);              // R5 never released -> fail
    run(4, 2, 0, 0, -1);               // R8 fail cleared by new start
    run(4, 2, 0, 1, -1);               // R7 SDA grabbed during STOP
    run(1, 1, 0, 0, -1);               // R3 half-period floor
    run(0, 0, 2, 1, -1);               // R7 R2 grab with no pulses
    run(156, 4, 0, 0, -1);             // fast rate
    run(625, 2, 3, 0, -1);             // standard rate
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule